// File: doc/BRIEF.md
# Asynchronous Timer Register Update Bridge

This block sits between a CPU register bus running on the system clock and an 8-bit timer that can be clocked either by the system clock or by a free-running external oscillator. Software writes to the timer's count, compare and control registers. Each write lands in a holding register on the bus side, and the holding register is then carried into the timer clock domain by a per-register toggle handshake. While a transfer is in flight, that register's busy flag reads 1. Software polls the flag and writes again only once it reads 0.

The timer counts up while its run bit is set and compares the count with the live compare value on every timer edge. Each match is turned into a single-cycle pulse in the system domain, which can set an interrupt flag. Reading the count returns the live count, which crosses into the system domain in Gray code. Reading the compare or control register returns its holding register. The status register holds the clock-source select bit and the three busy flags.

Top module: `async_tmr_bridge`

## Requirements
- R1: Bus addresses are 0 count, 1 compare, 2 control and 3 status. The status byte is {4'b0000, clock select, count busy, compare busy, control busy}. Only bit 3 can be written, and every status bit is 0 after reset.
- R2: With clock select 0 the timer runs from `sys_clk`. With clock select 1 it runs from `osc_clk`.
- R3: A write to address 0, 1 or 2 while that register is not busy sets its busy flag from the next system cycle on.
- R4: The busy flag clears only after the request toggle has crossed two timer flops, the live register has loaded, and the acknowledge has crossed two system flops. With clock select 0, the live load happens on the 3rd edge after the write edge, and the flag reads 0 from the 5th edge after the write edge.
- R5: Reads of addresses 1 and 2 return the last value written, from the cycle after the write.
- R6: A read of address 0 returns the live count after two-flop Gray synchronisation. With clock select 0 this is the count as it was two cycles earlier.
- R7: Control bit 0 is the run bit. While it is set, the count rises by 1 on every timer edge and wraps from 255 to 0. A count load that is being applied wins over the increment on the same edge.
- R8: A timer edge on which the run bit is set and the count equals the live compare value produces exactly one system-cycle high on `cmp_match`. With clock select 0 this happens two cycles after that edge. With the run bit clear, there is no pulse.
- R9: A write to a register whose busy flag is set updates its holding register but starts no new transfer, and it does not extend the busy window. Whether the new value reaches the live register is not guaranteed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System and bus clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | 1 | External oscillator clock for the timer |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| cmp_match | output | 1 | One-cycle compare-match pulse in the system domain |

## Verification
The hardest cases to reach are the ones where a second write lands inside a running handshake: a write to the same register while it is busy, and a count load arriving while the counter is running. With the timer on the system clock, every latency is exact. The bench places a second compare write one cycle after the first, and loads the count while the counter runs near 255. A behavioural model that tracks busy windows and apply cycles then predicts every read and every match pulse, and the bench compares them on every cycle. The bench then switches to the oscillator and checks by polling: the flags clear, the count rises at the slower rate, and exactly one match pulse occurs.

// File: rtl/atb_pkg.sv
`timescale 1ns/1ps
package atb_pkg;
  typedef enum logic [1:0] {
    ADR_CNT  = 2'd0,
    ADR_CMP  = 2'd1,
    ADR_CTL  = 2'd2,
    ADR_STAT = 2'd3
  } atb_addr_e;
  localparam int unsigned NCHAN = 3;  // count, compare, control
  localparam int unsigned CH_CNT = 0;
  localparam int unsigned CH_CMP = 1;
  localparam int unsigned CH_CTL = 2;
endpackage

// File: rtl/atb_sync.sv
`timescale 1ns/1ps
module atb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stg
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[0] <= '0;
          else        stg_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[i] <= '0;
          else        stg_q[i] <= stg_q[i-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/atb_chan.sv
`timescale 1ns/1ps
module atb_chan #(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          sys_clk,
  input  logic          sys_rst_n,
  input  logic          tmr_clk,
  input  logic          tmr_rst_n,
  input  logic          wr_hit,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] hold_q,
  output logic          busy,
  output logic          apply
);
  logic          req_q, req_d, req_s;
  logic          ack_q, ack_s;
  logic [DW-1:0] hold_d;

  // system side: holding register and request toggle
  always_comb begin
    hold_d = hold_q;
    req_d  = req_q;
    if (wr_hit) begin
      hold_d = wdata;
      if (!busy) req_d = ~req_q;  // R9: no new launch while in flight
    end
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      hold_q <= '0;
      req_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      req_q  <= req_d;
    end
  end

  atb_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
    .clk(tmr_clk), .rst_n(tmr_rst_n), .d(req_q), .q(req_s));

  // timer side: acknowledge follows the synchronised request
  always_ff @(posedge tmr_clk or negedge tmr_rst_n) begin
    if (!tmr_rst_n) ack_q <= 1'b0;
    else            ack_q <= req_s;
  end
  assign apply = req_s ^ ack_q;

  atb_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
    .clk(sys_clk), .rst_n(sys_rst_n), .d(ack_q), .q(ack_s));

  assign busy = req_q ^ ack_s;

  assert_busy_set_R3: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    wr_hit && !busy |=> busy);

  assert_busy_rise_R9: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $rose(busy) |-> $past(wr_hit));
endmodule

// File: rtl/atb_cnt_xing.sv
`timescale 1ns/1ps
module atb_cnt_xing #(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          tmr_clk,
  input  logic          tmr_rst_n,
  input  logic [DW-1:0] cnt_next,
  input  logic          sys_clk,
  input  logic          sys_rst_n,
  output logic [DW-1:0] cnt_sys
);
  logic [DW-1:0] gray_q, gray_s;

  always_ff @(posedge tmr_clk or negedge tmr_rst_n) begin
    if (!tmr_rst_n) gray_q <= '0;
    else            gray_q <= cnt_next ^ (cnt_next >> 1);
  end

  atb_sync #(.W(DW), .STAGES(STAGES)) u_gray_sync (
    .clk(sys_clk), .rst_n(sys_rst_n), .d(gray_q), .q(gray_s));

  always_comb begin
    cnt_sys[DW-1] = gray_s[DW-1];
    for (int i = DW-2; i >= 0; i--) cnt_sys[i] = cnt_sys[i+1] ^ gray_s[i];
  end
endmodule

// File: rtl/atb_evt_sync.sv
`timescale 1ns/1ps
module atb_evt_sync #(
  parameter int STAGES = 2
) (
  input  logic tmr_clk,
  input  logic tmr_rst_n,
  input  logic evt,
  input  logic sys_clk,
  input  logic sys_rst_n,
  output logic pulse
);
  logic tgl_q, tgl_d, tgl_s, last_q;

  assign tgl_d = evt ? ~tgl_q : tgl_q;

  always_ff @(posedge tmr_clk or negedge tmr_rst_n) begin
    if (!tmr_rst_n) tgl_q <= 1'b0;
    else            tgl_q <= tgl_d;
  end

  atb_sync #(.W(1), .STAGES(STAGES)) u_tgl_sync (
    .clk(sys_clk), .rst_n(sys_rst_n), .d(tgl_q), .q(tgl_s));

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) last_q <= 1'b0;
    else            last_q <= tgl_s;
  end

  assign pulse = tgl_s ^ last_q;
endmodule

// File: rtl/async_tmr_bridge.sv
`timescale 1ns/1ps
module async_tmr_bridge
  import atb_pkg::*;
#(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          sys_clk,
  input  logic          sys_rst_n,
  input  logic          osc_clk,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          cmp_match
);
  localparam int SEL_BIT = 3;

  logic          clk_sel_q, clk_sel_d;
  logic          tmr_clk, tmr_rst_n;
  logic [DW-1:0] hold_w  [NCHAN];
  logic          busy_w  [NCHAN];
  logic          apply_w [NCHAN];
  logic [DW-1:0] cnt_q, cnt_d, cmp_q, cmp_d, cnt_rd;
  logic          en_q, en_d, evt;

  // clock-source select, written through the status address
  assign clk_sel_d = (bus_wr && bus_addr == ADR_STAT) ? bus_wdata[SEL_BIT] : clk_sel_q;

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) clk_sel_q <= 1'b0;
    else            clk_sel_q <= clk_sel_d;
  end

  assign tmr_clk = clk_sel_q ? osc_clk : sys_clk;

  atb_sync #(.W(1), .STAGES(STAGES)) u_tmr_rst (
    .clk(tmr_clk), .rst_n(sys_rst_n), .d(1'b1), .q(tmr_rst_n));

  genvar k;
  generate
    for (k = 0; k < NCHAN; k++) begin : g_chan
      atb_chan #(.DW(DW), .STAGES(STAGES)) u_chan (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
        .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n),
        .wr_hit(bus_wr && bus_addr == 2'(k)),
        .wdata(bus_wdata), .hold_q(hold_w[k]),
        .busy(busy_w[k]), .apply(apply_w[k]));
    end
  endgenerate

  // timer domain next state
  always_comb begin
    cnt_d = cnt_q;
    if (apply_w[CH_CNT])  cnt_d = hold_w[CH_CNT];
    else if (en_q)        cnt_d = cnt_q + 1'b1;
    cmp_d = apply_w[CH_CMP] ? hold_w[CH_CMP] : cmp_q;
    en_d  = apply_w[CH_CTL] ? hold_w[CH_CTL][0] : en_q;
    evt   = en_q && (cnt_q == cmp_q);
  end

  always_ff @(posedge tmr_clk or negedge tmr_rst_n) begin
    if (!tmr_rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      cmp_q <= cmp_d;
      en_q  <= en_d;
    end
  end

  atb_cnt_xing #(.DW(DW), .STAGES(STAGES)) u_cnt_xing (
    .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n), .cnt_next(cnt_d),
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .cnt_sys(cnt_rd));

  atb_evt_sync #(.STAGES(STAGES)) u_evt_sync (
    .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n), .evt(evt),
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .pulse(cmp_match));

  // read-back
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_CNT: bus_rdata = cnt_rd;
      ADR_CMP: bus_rdata = hold_w[CH_CMP];
      ADR_CTL: bus_rdata = hold_w[CH_CTL];
      default: begin
        bus_rdata[SEL_BIT] = clk_sel_q;
        bus_rdata[2]       = busy_w[CH_CNT];
        bus_rdata[1]       = busy_w[CH_CMP];
        bus_rdata[0]       = busy_w[CH_CTL];
      end
    endcase
  end

  assert_status_hi_zero_R1: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    bus_addr == ADR_STAT |-> bus_rdata[DW-1:4] == '0);

  assert_cnt_step_R7: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    en_q && !apply_w[CH_CNT] |=> cnt_q == DW'($past(cnt_q) + 1'b1));
endmodule

// File: tb/async_tmr_bridge_test.sv
`timescale 1ns/1ps
module async_tmr_bridge_test;
  logic       clk = 1'b0, osc = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       match;

  int total = 0, bad = 0;
  bit done = 0, model_on = 0, async_on = 0;
  int pulse_cnt = 0;

  always #10   clk = ~clk;   // 50 MHz
  always #18.5 osc = ~osc;

  async_tmr_bridge uut (
    .sys_clk(clk), .sys_rst_n(rst_n), .osc_clk(osc),
    .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata), .cmp_match(match));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference (timer on sys_clk) ----------------
  int cyc = 0, last_c = -1;
  logic [7:0] m_hold [3];
  logic [7:0] m_cmp = 0, m_cnt = 0;
  logic m_en = 0, m_sel = 0;
  int m_bend [3];
  int m_app [3];
  logic [7:0] cnt_hist [8];
  logic evt_hist [8];

  initial begin
    for (int i = 0; i < 3; i++) begin m_hold[i] = 0; m_bend[i] = -10; m_app[i] = -1; end
    for (int i = 0; i < 8; i++) begin cnt_hist[i] = 0; evt_hist[i] = 0; end
  end

  always @(posedge clk) begin
    if (model_on) begin
      logic ev;
      logic [7:0] nc;
      ev = m_en && (m_cnt == m_cmp);
      nc = m_cnt;
      if (m_app[0] == cyc) nc = m_hold[0];           // R7 load wins
      else if (m_en) nc = m_cnt + 8'd1;
      if (m_app[1] == cyc) m_cmp = m_hold[1];
      if (m_app[2] == cyc) m_en = m_hold[2][0];
      m_cnt = nc;
      if (wr) begin
        if (addr == 2'd3) m_sel = wdata[3];
        else begin
          m_hold[addr] = wdata;
          if (cyc - 1 > m_bend[addr]) begin          // R9: busy write launches nothing
            m_app[addr]  = cyc + 3;                   // R4 load edge
            m_bend[addr] = cyc + 4;                   // R4 last busy cycle
          end
        end
      end
      cnt_hist[cyc % 8] = m_cnt;
      evt_hist[cyc % 8] = ev;
      last_c = cyc;
      cyc++;
    end
  end

  always @(negedge clk) begin
    if (model_on && last_c >= 0) begin
      logic [7:0] exp;
      logic ep;
      case (addr)
        2'd0: begin
          exp = (last_c >= 2) ? cnt_hist[(last_c - 2) % 8] : 8'h00;
          chk("R6 R7 count read", rdata, exp);
        end
        2'd1: chk("R5 R9 compare hold", rdata, m_hold[1]);
        2'd2: chk("R5 control hold", rdata, m_hold[2]);
        default: begin
          exp = {4'b0000, m_sel, last_c <= m_bend[0], last_c <= m_bend[1], last_c <= m_bend[2]};
          chk("R1 R3 R4 status", rdata, exp);
        end
      endcase
      ep = (last_c >= 2) ? evt_hist[(last_c - 2) % 8] : 1'b0;
      chk("R8 match pulse", {7'b0, match}, {7'b0, ep});
    end
    if (async_on && match) pulse_cnt++;
  end

  // ---------------- stimulus ----------------
  int rot = 0;
  task automatic step(input logic w, input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #4;
    wr = w; addr = a; wdata = d;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin step(1'b0, 2'(rot), 8'h00); rot++; end
  endtask
  task automatic wait_clear(input int b, input string tag);
    logic ok;
    ok = 0;
    for (int i = 0; i < 80 && !ok; i++) begin
      step(1'b0, 2'd3, 8'h00);
      @(negedge clk);
      if (rdata[b] == 1'b0) ok = 1;
    end
    chk(tag, {7'b0, ok}, 8'h01);
  endtask

  initial begin
    logic [7:0] c0, c1;
    int diff;
    // reset state, R1
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a);
      @(negedge clk);
      chk("R1 reset read", rdata, 8'h00);
    end
    chk("R8 reset match", {7'b0, match}, 8'h00);
    @(posedge clk); #4; rst_n = 1'b1; model_on = 1;
    idle(6);
    step(1'b1, 2'd1, 8'h05); idle(7);            // R3 R4 R5 compare update
    step(1'b1, 2'd2, 8'h01); idle(20);           // R7 run, R8 match at 5
    step(1'b1, 2'd0, 8'hFA); idle(14);           // R7 load while running, wrap 255->0
    step(1'b1, 2'd1, 8'h07);
    step(1'b1, 2'd1, 8'h08); idle(10);           // R9 write while busy
    step(1'b1, 2'd0, 8'h03);
    step(1'b1, 2'd2, 8'h81); idle(16);           // R8 match at 8
    step(1'b1, 2'd2, 8'hA4); idle(10);           // R7 stop
    step(1'b1, 2'd0, 8'h08); idle(10);           // R8 no pulse while stopped
    step(1'b1, 2'd3, 8'hF0); idle(6);            // R1 only bit 3 writable
    model_on = 0;

    // -------- oscillator mode, R2 --------
    step(1'b1, 2'd3, 8'h08);
    step(1'b0, 2'd3, 8'h00); @(negedge clk);
    chk("R1 R2 select set", rdata, 8'h08);
    idle(8);
    step(1'b1, 2'd1, 8'h40);
    step(1'b0, 2'd3, 8'h00); @(negedge clk);
    chk("R3 busy set async", {7'b0, rdata[1]}, 8'h01);
    wait_clear(1, "R4 compare busy clears async");
    step(1'b0, 2'd1, 8'h00); @(negedge clk);
    chk("R5 compare read async", rdata, 8'h40);
    step(1'b1, 2'd0, 8'h10);
    wait_clear(2, "R4 count busy clears async");
    step(1'b0, 2'd0, 8'h00); @(negedge clk);
    chk("R2 count loaded async", rdata, 8'h10);
    async_on = 1;
    step(1'b1, 2'd2, 8'h01);
    wait_clear(0, "R4 control busy clears async");
    step(1'b0, 2'd0, 8'h00); @(negedge clk); c0 = rdata;
    idle(40);
    step(1'b0, 2'd0, 8'h00); @(negedge clk); c1 = rdata;
    diff = int'(c1) - int'(c0);
    chk("R2 oscillator rate", {7'b0, diff >= 12 && diff <= 32}, 8'h01);
    idle(200);
    chk("R8 single pulse async", 8'(pulse_cnt), 8'h01);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule